// File: doc/BRIEF.md
# Cache Control Register Block

This block holds the control word that software uses to govern a processor's instruction cache and data cache. The word carries a two-bit operating state for each cache, a freeze-on-interrupt enable for each cache, and any further control bits that software chooses to keep there. Two more word addresses return fixed configuration values that describe the caches. The block drives both state fields out as ports, so that the cache logic can follow them directly.

The block sits on a simple register bus with an address, a write enable, a read enable, an access size in bytes, write data and read data. Only full 32-bit accesses take effect. The write-only command bits and the status bits in the control word are dropped when the word is written, so they always read back as zero. A separate one-cycle input marks the moment the core takes an interrupt. On that pulse, each cache whose freeze enable is set and whose state is enabled drops to frozen. This lets a handler run without disturbing the cache contents.

Top module: `cache_ctl_regs`

## Requirements
- R1: While reset is held and after it is released, both state outputs read 00 (disabled) and the read data is zero. An asserted reset clears any value that was stored before it.
- R2: The instruction cache state is control bits [1:0] and the data cache state is bits [3:2], driven on `icacheState` and `dcacheState`. The encodings are 00 disabled, 01 frozen and 11 enabled.
- R3: A 4-byte write to offset 0x00 stores the write data with bits 14, 15, 16, 21 and 22 forced to zero. All other bits, bit 23 among them, are stored as written and read back unchanged.
- R4: When `irqTaken` is high and control bit 4 is set, an instruction cache state of 11 becomes 01 on the next clock.
- R5: When `irqTaken` is high and control bit 5 is set, a data cache state of 11 becomes 01 on the next clock.
- R6: The control word does not change on an interrupt pulse if the matching freeze bit is clear or the state is not 11. It also does not change in a cycle with no write and no interrupt pulse.
- R7: When a control write and `irqTaken` fall in the same cycle, the freeze rule is applied to the newly written value.
- R8: A 4-byte read of offset 0x04 returns 0x10220000 and of offset 0x08 returns 0x18220000. Writes to these offsets change nothing.
- R9: An access whose size is not 4 bytes changes nothing when written and returns zero when read.
- R10: A read of an offset other than 0x00, 0x04 or 0x08 returns zero, and a write to such an offset changes nothing.
- R11: Read data appears on the clock edge that follows the read request and holds until the next read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Byte offset of the access |
| busWrEn | input | 1 | Write request |
| busRdEn | input | 1 | Read request |
| busSize | input | 3 | Access size in bytes; only 4 is honoured |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Registered read data |
| irqTaken | input | 1 | One-cycle pulse when the core takes an interrupt |
| icacheState | output | 2 | Instruction cache state field |
| dcacheState | output | 2 | Data cache state field |

## Verification
The hardest case to reach is a write and an interrupt pulse in the same cycle, where the freeze rule has to act on the incoming data rather than on the stored word. The stimulus table holds rows that raise `irqTaken` together with a control write. In some of those rows both caches are written as enabled with both freeze bits set, and in others no freeze bits are set. The table also lines up a frozen or disabled state against an interrupt pulse, to show that only the enabled state moves.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

  localparam int DATA_W     = 32;
  localparam int SIZE_W     = 3;
  localparam int NUM_CACHES = 2;
  localparam int STATE_W    = 2;
  localparam int FRZ_BASE   = 4;     // freeze enables sit just above the state fields

  localparam logic [SIZE_W-1:0] WORD_BYTES = 3'd4;

  localparam int CTRL_OFF = 'h00;
  localparam int ICFG_OFF = 'h04;
  localparam int DCFG_OFF = 'h08;

  localparam logic [DATA_W-1:0] ICFG_VAL = 32'h1022_0000;
  localparam logic [DATA_W-1:0] DCFG_VAL = 32'h1822_0000;

  // flush-pending (14,15), burst fetch (16), flush commands (21,22)
  localparam logic [DATA_W-1:0] WR_MASK =
    (32'h1 << 14) | (32'h1 << 15) | (32'h1 << 16) | (32'h1 << 21) | (32'h1 << 22);

  localparam logic [STATE_W-1:0] ST_OFF = 2'b00;
  localparam logic [STATE_W-1:0] ST_FRZ = 2'b01;
  localparam logic [STATE_W-1:0] ST_ON  = 2'b11;

  typedef enum logic [1:0] {
    SEL_ZERO,
    SEL_CTRL,
    SEL_ICFG,
    SEL_DCFG
  } rdSel_e;

  typedef struct packed {
    logic   ctrlWr;
    logic   rdStb;
    rdSel_e rdSel;
  } strobes_t;

endpackage

// File: rtl/ccr_decode.sv
module ccr_decode
  import ccr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [SIZE_W-1:0] busSize,
  output strobes_t          stb
);

  logic wordOk;
  logic hitCtrl;
  logic hitIcfg;
  logic hitDcfg;

  always_comb begin
    wordOk  = (busSize == WORD_BYTES);
    hitCtrl = (busAddr == ADDR_W'(CTRL_OFF));
    hitIcfg = (busAddr == ADDR_W'(ICFG_OFF));
    hitDcfg = (busAddr == ADDR_W'(DCFG_OFF));

    stb.ctrlWr = busWrEn && wordOk && hitCtrl;
    stb.rdStb  = busRdEn;

    if (!wordOk)      stb.rdSel = SEL_ZERO;
    else if (hitCtrl) stb.rdSel = SEL_CTRL;
    else if (hitIcfg) stb.rdSel = SEL_ICFG;
    else if (hitDcfg) stb.rdSel = SEL_DCFG;
    else              stb.rdSel = SEL_ZERO;
  end

endmodule

// File: rtl/ccr_datapath.sv
module ccr_datapath
  import ccr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              irqTaken,
  output logic [DATA_W-1:0] ctrlVal,
  output logic [DATA_W-1:0] rdData
);

  localparam int FIELD_W = NUM_CACHES * STATE_W;

  logic [DATA_W-1:0]  ctrlQ;
  logic [DATA_W-1:0]  staged;
  logic [FIELD_W-1:0] nextField;
  logic [DATA_W-1:0]  ctrlD;
  logic [DATA_W-1:0]  rdNext;

  assign staged = stb.ctrlWr ? (wrData & ~WR_MASK) : ctrlQ;

  for (genvar gi = 0; gi < NUM_CACHES; gi++) begin : g_frz
    logic [STATE_W-1:0] cur;
    logic               doFreeze;
    assign cur      = staged[gi*STATE_W +: STATE_W];
    assign doFreeze = irqTaken && staged[FRZ_BASE + gi] && (cur == ST_ON);
    assign nextField[gi*STATE_W +: STATE_W] = doFreeze ? ST_FRZ : cur;
  end

  assign ctrlD = {staged[DATA_W-1:FIELD_W], nextField};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlQ <= '0;
    else       ctrlQ <= ctrlD;
  end

  always_comb begin
    unique case (stb.rdSel)
      SEL_CTRL: rdNext = ctrlQ;
      SEL_ICFG: rdNext = ICFG_VAL;
      SEL_DCFG: rdNext = DCFG_VAL;
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdData <= '0;
    else if (stb.rdStb) rdData <= rdNext;
  end

  assign ctrlVal = ctrlQ;

endmodule

// File: rtl/cache_ctl_regs.sv
module cache_ctl_regs
  import ccr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [2:0]        busSize,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  input  logic              irqTaken,
  output logic [1:0]        icacheState,
  output logic [1:0]        dcacheState
);

  strobes_t          stb;
  logic [DATA_W-1:0] ctrlVal;

  ccr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .busSize (busSize),
    .stb     (stb)
  );

  ccr_datapath u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrData   (busWrData),
    .irqTaken (irqTaken),
    .ctrlVal  (ctrlVal),
    .rdData   (busRdData)
  );

  assign icacheState = ctrlVal[1:0];
  assign dcacheState = ctrlVal[3:2];

endmodule

// File: rtl/ccr_checker.sv
module ccr_checker
  import ccr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [2:0]        busSize,
  input logic [31:0]       busRdData,
  input logic              irqTaken,
  input logic [31:0]       ctrlVal,
  input logic [1:0]        icacheState,
  input logic [1:0]        dcacheState
);

  p_freeze_i_r4: assert property (@(posedge clk) disable iff (!rstN)
    (irqTaken && !busWrEn && ctrlVal[4] && icacheState == 2'b11) |=> icacheState == 2'b01);

  p_freeze_d_r5: assert property (@(posedge clk) disable iff (!rstN)
    (irqTaken && !busWrEn && ctrlVal[5] && dcacheState == 2'b11) |=> dcacheState == 2'b01);

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!busWrEn && !irqTaken) |=> $stable(ctrlVal));

  p_irq_nofrz_r6: assert property (@(posedge clk) disable iff (!rstN)
    (irqTaken && !busWrEn && !ctrlVal[4] && !ctrlVal[5]) |=> $stable(ctrlVal));

  p_ro_mask_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busSize == 3'd4 && busAddr == ADDR_W'(CTRL_OFF)) |=> (busRdData & WR_MASK) == '0);

  p_icfg_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busSize == 3'd4 && busAddr == ADDR_W'(ICFG_OFF)) |=> busRdData == 32'h1022_0000);

  p_dcfg_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busSize == 3'd4 && busAddr == ADDR_W'(DCFG_OFF)) |=> busRdData == 32'h1822_0000);

  p_narrow_rd_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busSize != 3'd4) |=> busRdData == '0);

  p_narrow_wr_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busSize != 3'd4 && !irqTaken) |=> $stable(ctrlVal));

  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> $stable(busRdData));

endmodule

bind cache_ctl_regs ccr_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/cache_ctl_regs_bench.sv
module cache_ctl_regs_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 8;
  localparam int WATCHDOG   = 5000;

  // kind: 0 write, 1 read, 2 interrupt pulse only
  typedef struct packed {
    logic [1:0]  kind;
    logic [7:0]  addr;
    logic [2:0]  size;
    logic [31:0] data;
    logic        irq;
    logic [31:0] expRd;
    logic [1:0]  expI;
    logic [1:0]  expD;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    // R3: masked bits dropped, bit 23 kept
    '{2'd0, 8'h00, 3'd4, 32'h00E0_C03F, 1'b0, 32'h0,         2'd3, 2'd3, 8'd3},
    '{2'd1, 8'h00, 3'd4, 32'h0,         1'b0, 32'h0080_003F, 2'd3, 2'd3, 8'd3},
    // R4, R5: both freeze on pulse
    '{2'd2, 8'h00, 3'd4, 32'h0,         1'b1, 32'h0,         2'd1, 2'd1, 8'd4},
    '{2'd1, 8'h00, 3'd4, 32'h0,         1'b0, 32'h0080_0035, 2'd1, 2'd1, 8'd5},
    // R4 only instruction freeze enabled
    '{2'd0, 8'h00, 3'd4, 32'h0000_001F, 1'b0, 32'h0,         2'd3, 2'd3, 8'd2},
    '{2'd2, 8'h00, 3'd4, 32'h0,         1'b1, 32'h0,         2'd1, 2'd3, 8'd4},
    // R5 only data freeze enabled
    '{2'd0, 8'h00, 3'd4, 32'h0000_002F, 1'b0, 32'h0,         2'd3, 2'd3, 8'd2},
    '{2'd2, 8'h00, 3'd4, 32'h0,         1'b1, 32'h0,         2'd3, 2'd1, 8'd5},
    // R6: pulse repeated on frozen/enabled with bit clear
    '{2'd2, 8'h00, 3'd4, 32'h0,         1'b1, 32'h0,         2'd3, 2'd1, 8'd6},
    // R7: write with pulse, no freeze bits
    '{2'd0, 8'h00, 3'd4, 32'h0000_000C, 1'b1, 32'h0,         2'd0, 2'd3, 8'd7},
    // R7: write with pulse, both freeze bits and both enabled
    '{2'd0, 8'h00, 3'd4, 32'h0000_003F, 1'b1, 32'h0,         2'd1, 2'd1, 8'd7},
    '{2'd1, 8'h00, 3'd4, 32'h0,         1'b0, 32'h0000_0035, 2'd1, 2'd1, 8'd7},
    // R6: frozen and disabled stay put under pulse
    '{2'd0, 8'h00, 3'd4, 32'h0000_0031, 1'b0, 32'h0,         2'd1, 2'd0, 8'd6},
    '{2'd2, 8'h00, 3'd4, 32'h0,         1'b1, 32'h0,         2'd1, 2'd0, 8'd6},
    // R8: configuration words
    '{2'd1, 8'h04, 3'd4, 32'h0,         1'b0, 32'h1022_0000, 2'd1, 2'd0, 8'd8},
    '{2'd1, 8'h08, 3'd4, 32'h0,         1'b0, 32'h1822_0000, 2'd1, 2'd0, 8'd8},
    '{2'd0, 8'h04, 3'd4, 32'hFFFF_FFFF, 1'b0, 32'h0,         2'd1, 2'd0, 8'd8},
    '{2'd0, 8'h08, 3'd4, 32'hFFFF_FFFF, 1'b0, 32'h0,         2'd1, 2'd0, 8'd8},
    '{2'd1, 8'h04, 3'd4, 32'h0,         1'b0, 32'h1022_0000, 2'd1, 2'd0, 8'd8},
    '{2'd1, 8'h00, 3'd4, 32'h0,         1'b0, 32'h0000_0031, 2'd1, 2'd0, 8'd8},
    // R9: narrow and wide accesses
    '{2'd0, 8'h00, 3'd2, 32'h0000_000F, 1'b0, 32'h0,         2'd1, 2'd0, 8'd9},
    '{2'd0, 8'h00, 3'd1, 32'h0000_000F, 1'b0, 32'h0,         2'd1, 2'd0, 8'd9},
    '{2'd1, 8'h00, 3'd2, 32'h0,         1'b0, 32'h0,         2'd1, 2'd0, 8'd9},
    '{2'd1, 8'h04, 3'd0, 32'h0,         1'b0, 32'h0,         2'd1, 2'd0, 8'd9},
    // R10: unmapped offsets
    '{2'd0, 8'h0C, 3'd4, 32'h0000_000F, 1'b0, 32'h0,         2'd1, 2'd0, 8'd10},
    '{2'd1, 8'h0C, 3'd4, 32'h0,         1'b0, 32'h0,         2'd1, 2'd0, 8'd10},
    '{2'd1, 8'h10, 3'd4, 32'h0,         1'b0, 32'h0,         2'd1, 2'd0, 8'd10}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busWrEn = 1'b0;
  logic              busRdEn = 1'b0;
  logic [2:0]        busSize = '0;
  logic [31:0]       busWrData = '0;
  logic [31:0]       busRdData;
  logic              irqTaken = 1'b0;
  logic [1:0]        icacheState;
  logic [1:0]        dcacheState;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_ctl_regs #(.ADDR_W(ADDR_W)) u_cache_ctl_regs (
    .clk         (clk),
    .rstN        (rstN),
    .busAddr     (busAddr),
    .busWrEn     (busWrEn),
    .busRdEn     (busRdEn),
    .busSize     (busSize),
    .busWrData   (busWrData),
    .busRdData   (busRdData),
    .irqTaken    (irqTaken),
    .icacheState (icacheState),
    .dcacheState (dcacheState)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one operation for one clock; sample after the edge.
  task automatic doOp(input logic [1:0] kind, input logic [7:0] addr, input logic [2:0] size,
                      input logic [31:0] data, input logic irq);
    @(negedge clk);
    busAddr   = addr;
    busSize   = size;
    busWrData = data;
    busWrEn   = (kind == 2'd0);
    busRdEn   = (kind == 2'd1);
    irqTaken  = irq;
    @(negedge clk);
    busWrEn   = 1'b0;
    busRdEn   = 1'b0;
    irqTaken  = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 icache state in reset", {30'd0, icacheState}, 32'd0);
    check("R1 read data in reset", busRdData, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 dcache state after reset", {30'd0, dcacheState}, 32'd0);
    doOp(2'd1, 8'h00, 3'd4, 32'd0, 1'b0);
    check("R1 control reads zero after reset", busRdData, 32'd0);

    for (int i = 0; i < NV; i++) begin
      doOp(VECS[i].kind, VECS[i].addr, VECS[i].size, VECS[i].data, VECS[i].irq);
      if (VECS[i].kind == 2'd1)
        check($sformatf("R%0d row %0d read data", VECS[i].req, i), busRdData, VECS[i].expRd);
      check($sformatf("R%0d row %0d icache state (R2)", VECS[i].req, i),
            {30'd0, icacheState}, {30'd0, VECS[i].expI});
      check($sformatf("R%0d row %0d dcache state (R2)", VECS[i].req, i),
            {30'd0, dcacheState}, {30'd0, VECS[i].expD});
    end

    // R11: read data lands one edge after request, then holds
    doOp(2'd1, 8'h08, 3'd4, 32'd0, 1'b0);
    check("R11 read data one cycle after request", busRdData, 32'h1822_0000);
    doOp(2'd0, 8'h00, 3'd4, 32'h0000_000F, 1'b0);
    check("R11 read data holds across write", busRdData, 32'h1822_0000);
    repeat (3) @(negedge clk);
    check("R11 read data holds while idle", busRdData, 32'h1822_0000);

    // R1: reset in mid-run clears stored word
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 icache cleared by reset", {30'd0, icacheState}, 32'd0);
    check("R1 dcache cleared by reset", {30'd0, dcacheState}, 32'd0);
    check("R1 read data cleared by reset", busRdData, 32'd0);
    rstN = 1'b1;
    doOp(2'd1, 8'h00, 3'd4, 32'd0, 1'b0);
    check("R1 control word zero after second reset", busRdData, 32'd0);

    finishRun();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

endmodule